// File: doc/BRIEF.md
# Dual-Channel GPIO with Change Interrupt

This peripheral gives a host two banks of general-purpose pins, each from 1 to 32 bits wide, behind a small 32-bit register port. For every bank the host programs an output latch and a direction mask. The block drives the pad output and output-enable lines from them and returns the pin levels, after a two-flop synchroniser, when the data register is read. The second bank is present only when the dual-bank parameter is set. With the parameter clear, the second bank reads as zero and never drives its pads.

Each bank has one "something moved" flag. The flag is set when any synchronised input bit of the bank differs from its value one cycle earlier. The host clears a flag by writing a one to it. A per-bank enable mask and a master enable bit together decide whether the single interrupt line is raised. The host normally reads the status, writes the same value back to acknowledge it, and then reads the data registers to find out which pins moved.

The register port takes requests on a valid/ready pair. Ready is held high, so the port never applies back-pressure and a request is taken in any cycle in which valid is high. A read produces `rsp_valid` for exactly one cycle, one clock after the request is accepted, carrying the read data. The response cannot be stalled, so the host must be able to take it in that cycle.

Top module: `gpio_dual_top`

## Requirements
- R1: Reset state. Output latches take their per-bank reset parameters (default zero) and direction registers take theirs (default all ones, so every pin is an input and `chN_oe` is zero). The master enable, the enable mask and the status flags reset to zero, and `irq` is low.
- R2: Register offsets: bank-1 data at 0x000, bank-1 direction at 0x004, bank-2 data at 0x008, bank-2 direction at 0x00C. A direction bit of 1 makes the pin an input (`oe`=0). A direction bit of 0 drives the pin from the output latch (`oe`=1, `out`=latch bit). A direction register reads back the value written to it.
- R3: Reading a data register returns the pin inputs after a two-flop synchroniser, including pins configured as outputs, which return the level seen on the pad.
- R4: The status register is at 0x120. Bit 0 is set when any synchronised bit of bank 1 changes, and bit 1 is set when any synchronised bit of bank 2 changes. There is one flag per bank.
- R5: A write to the status register clears each flag whose write-data bit is 1 and leaves the others unchanged. If a change arrives in the same cycle as the clear, the flag stays set.
- R6: The enable mask is at 0x128, with bit 0 for bank 1 and bit 1 for bank 2. The master enable is bit 31 at 0x11C. `irq` is high exactly when the master enable is set and some status bit is set with its enable bit also set.
- R7: Write bits above a bank's width are ignored and read back as zero. The same holds for bits 30:0 of 0x11C and bits 31:2 of 0x128. Writes to unmapped offsets have no effect, and reads of unmapped offsets return zero.
- R8: `req_ready` is always 1. `rsp_valid` is high one cycle after each accepted read and at no other time. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R9: With the dual-bank parameter clear, the bank-2 registers read zero, `ch2_oe` and `ch2_out` stay zero, bit 1 of the status and enable registers stays zero, and activity on `ch2_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data, zero when not valid |
| ch1_in | input | W1 | Bank-1 pad input levels |
| ch1_out | output | W1 | Bank-1 pad output levels |
| ch1_oe | output | W1 | Bank-1 pad output enables |
| ch2_in | input | W2 | Bank-2 pad input levels |
| ch2_out | output | W2 | Bank-2 pad output levels |
| ch2_oe | output | W2 | Bank-2 pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that the register port is the only way to reach the direction and status state. It also assumes that the pad inputs may change at any cycle, and it never relies on the pins staying stable. The stimulus changes pins and requests only at falling clock edges and holds the bench pad model combinational (driven where `oe` is set, otherwise the external level). It waits enough cycles for the synchroniser before reading a pin or a status flag. Only the set-versus-clear collision is timed to the exact cycle, and that request is placed on the edge where the change reaches the status register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int NBANK  = 2;

  localparam logic [ADDR_W-1:0] OFS_DAT1 = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR1 = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_DAT2 = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DIR2 = 9'h00C;
  localparam logic [ADDR_W-1:0] OFS_MSTR = 9'h11C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_MASK = 9'h128;

  localparam int MSTR_BIT = 31;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DAT1, SEL_DIR1, SEL_DAT2, SEL_DIR2, SEL_MSTR, SEL_STAT, SEL_MASK
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DAT1: return SEL_DAT1;
      OFS_DIR1: return SEL_DIR1;
      OFS_DAT2: return SEL_DAT2;
      OFS_DIR2: return SEL_DIR2;
      OFS_MSTR: return SEL_MSTR;
      OFS_STAT: return SEL_STAT;
      OFS_MASK: return SEL_MASK;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_pkg::*; #(
  parameter int          W        = 32,
  parameter logic [31:0] LATCH_RST = 32'h0,
  parameter logic [31:0] DIR_RST   = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_latch,
  input  logic              wr_dir,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [DATA_W-1:0] rd_pins,
  output logic [DATA_W-1:0] rd_dir,
  output logic              moved
);
  logic [W-1:0] latch_q, dir_q, pins_s, prev_q;

  gpio_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pins_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= LATCH_RST[W-1:0];
      dir_q   <= DIR_RST[W-1:0];
      prev_q  <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
      prev_q <= pins_s;
    end
  end

  assign pad_out = latch_q;
  assign pad_oe  = ~dir_q;
  assign moved   = |(pins_s ^ prev_q);
  assign rd_pins = DATA_W'(pins_s);
  assign rd_dir  = DATA_W'(dir_q);
endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl import gpio_pkg::*; #(
  parameter bit DUAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] moved,
  input  logic             wr_mstr,
  input  logic             wr_stat,
  input  logic             wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic             mstr_en,
  output logic [NBANK-1:0] stat,
  output logic [NBANK-1:0] mask,
  output logic             irq
);
  localparam logic [NBANK-1:0] LIVE = DUAL ? 2'b11 : 2'b01;

  logic [NBANK-1:0] clr;

  assign clr = wr_stat ? wdata[NBANK-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstr_en <= 1'b0;
      stat    <= '0;
      mask    <= '0;
    end else begin
      if (wr_mstr) mstr_en <= wdata[MSTR_BIT];
      if (wr_mask) mask    <= wdata[NBANK-1:0] & LIVE;
      stat <= ((stat & ~clr) | moved) & LIVE;
    end
  end

  assign irq = mstr_en & |(stat & mask);
endmodule

// File: rtl/gpio_dual_top.sv
module gpio_dual_top import gpio_pkg::*; #(
  parameter int unsigned W1         = 32,
  parameter int unsigned W2         = 32,
  parameter bit          DUAL       = 1'b1,
  parameter logic [31:0] LATCH1_RST = 32'h0,
  parameter logic [31:0] DIR1_RST   = 32'hFFFF_FFFF,
  parameter logic [31:0] LATCH2_RST = 32'h0,
  parameter logic [31:0] DIR2_RST   = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [W1-1:0]     ch1_in,
  output logic [W1-1:0]     ch1_out,
  output logic [W1-1:0]     ch1_oe,
  input  logic [W2-1:0]     ch2_in,
  output logic [W2-1:0]     ch2_out,
  output logic [W2-1:0]     ch2_oe,
  output logic              irq
);
  reg_sel_e         sel;
  logic             take, wr, rd;
  logic [NBANK-1:0] moved, stat_q, mask_q;
  logic             mstr_q;
  logic [DATA_W-1:0] pins1, dir1, pins2, dir2, rd_mux;

  assign req_ready = 1'b1;
  assign take = req_valid & req_ready;
  assign wr   = take & req_write;
  assign rd   = take & ~req_write;
  assign sel  = decode_addr(req_addr);

  gpio_bank #(.W(W1), .LATCH_RST(LATCH1_RST), .DIR_RST(DIR1_RST)) u_bank1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_latch(wr && sel == SEL_DAT1),
    .wr_dir  (wr && sel == SEL_DIR1),
    .wdata   (req_wdata[W1-1:0]),
    .pad_in  (ch1_in),
    .pad_out (ch1_out),
    .pad_oe  (ch1_oe),
    .rd_pins (pins1),
    .rd_dir  (dir1),
    .moved   (moved[0])
  );

  generate
    if (DUAL) begin : g_bank2
      gpio_bank #(.W(W2), .LATCH_RST(LATCH2_RST), .DIR_RST(DIR2_RST)) u_bank2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_latch(wr && sel == SEL_DAT2),
        .wr_dir  (wr && sel == SEL_DIR2),
        .wdata   (req_wdata[W2-1:0]),
        .pad_in  (ch2_in),
        .pad_out (ch2_out),
        .pad_oe  (ch2_oe),
        .rd_pins (pins2),
        .rd_dir  (dir2),
        .moved   (moved[1])
      );
    end else begin : g_no_bank2
      assign ch2_out  = '0;
      assign ch2_oe   = '0;
      assign pins2    = '0;
      assign dir2     = '0;
      assign moved[1] = 1'b0;
    end
  endgenerate

  gpio_irq_ctl #(.DUAL(DUAL)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .moved  (moved),
    .wr_mstr(wr && sel == SEL_MSTR),
    .wr_stat(wr && sel == SEL_STAT),
    .wr_mask(wr && sel == SEL_MASK),
    .wdata  (req_wdata),
    .mstr_en(mstr_q),
    .stat   (stat_q),
    .mask   (mask_q),
    .irq    (irq)
  );

  always_comb begin
    case (sel)
      SEL_DAT1: rd_mux = pins1;
      SEL_DIR1: rd_mux = dir1;
      SEL_DAT2: rd_mux = pins2;
      SEL_DIR2: rd_mux = dir2;
      SEL_MSTR: rd_mux = {mstr_q, {(DATA_W-1){1'b0}}};
      SEL_STAT: rd_mux = DATA_W'(stat_q);
      SEL_MASK: rd_mux = DATA_W'(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_dual_chk.sv
module gpio_dual_chk import gpio_pkg::*; #(
  parameter int unsigned W1 = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [W1-1:0]     ch1_oe,
  input logic [NBANK-1:0]  stat,
  input logic              irq
);
  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r8_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && rsp_rdata == '0));

  a_r2_oe_moves_on_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch1_oe) |-> $past(req_valid && req_write && req_addr == OFS_DIR1));

  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(req_valid && req_write && req_addr == OFS_STAT && req_wdata[0])) |=> stat[0]);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));

  a_r6_master_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFS_MSTR && !req_wdata[MSTR_BIT]) |=> !irq);
endmodule

bind gpio_dual_top gpio_dual_chk #(.W1(W1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .ch1_oe   (ch1_oe),
  .stat     (stat_q),
  .irq      (irq)
);

// File: tb/tb_gpio_dual_top.sv
module tb_gpio_dual_top;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, use_single = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] ext1 = '0, ext2 = '0;
  logic [SW-1:0] sext1 = '0;

  logic        m_ready, m_rv, m_irq;
  logic [31:0] m_rd, m_out1, m_oe1, m_out2, m_oe2, m_in1, m_in2;
  logic        s_ready, s_rv, s_irq;
  logic [31:0] s_rd, s_out2, s_oe2;
  logic [SW-1:0] s_out1, s_oe1, s_in1;

  assign m_in1 = (m_oe1 & m_out1) | (~m_oe1 & ext1);
  assign m_in2 = (m_oe2 & m_out2) | (~m_oe2 & ext2);
  assign s_in1 = (s_oe1 & s_out1) | (~s_oe1 & sext1);

  gpio_dual_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !use_single), .req_ready(m_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(m_rv), .rsp_rdata(m_rd), .ch1_in(m_in1), .ch1_out(m_out1), .ch1_oe(m_oe1),
    .ch2_in(m_in2), .ch2_out(m_out2), .ch2_oe(m_oe2), .irq(m_irq));

  gpio_dual_top #(.W1(SW), .DUAL(1'b0), .LATCH1_RST(32'hFFFF_FF3C), .DIR1_RST(32'h0000_000F)) dut_single (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && use_single), .req_ready(s_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(s_rv), .rsp_rdata(s_rd), .ch1_in(s_in1), .ch1_out(s_out1), .ch1_oe(s_oe1),
    .ch2_in(ext2), .ch2_out(s_out2), .ch2_oe(s_oe2), .irq(s_irq));

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called just after a falling edge, returns after the next one
  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each read response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (use_single ? s_rv : m_rv)) begin
      if (exp_q.size() == 0) chk("R8 unexpected response", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), use_single ? s_rd : m_rd, exp_q.pop_front());
    end
  end

  logic done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 ch1_oe", m_oe1, 32'h0);
    chk("R1 ch1_out", m_out1, 32'h0);
    chk("R1 ch2_oe", m_oe2, 32'h0);
    chk("R1 irq", {31'b0, m_irq}, 32'h0);
    chk("R8 ready", {31'b0, m_ready}, 32'h1);
    rd(9'h004, 32'hFFFF_FFFF, "R1 dir1 reset");
    rd(9'h00C, 32'hFFFF_FFFF, "R1 dir2 reset");
    rd(9'h120, 32'h0, "R1 status reset");
    rd(9'h128, 32'h0, "R1 mask reset");
    rd(9'h11C, 32'h0, "R1 master reset");
    // R2 latch and direction
    wr(9'h000, 32'hA5A5_0F0F);
    chk("R2 out follows latch", m_out1, 32'hA5A5_0F0F);
    chk("R8 no rsp after write", {31'b0, m_rv}, 32'h0);
    chk("R2 oe stays off", m_oe1, 32'h0);
    rd(9'h000, 32'h0, "R3 input pins read");
    wr(9'h004, 32'hFFFF_0000);
    chk("R2 oe from dir", m_oe1, 32'h0000_FFFF);
    idle(4);
    rd(9'h000, 32'h0000_0F0F, "R3 output pins read pad");
    rd(9'h004, 32'hFFFF_0000, "R2 dir readback");
    ext1 = 32'h1234_0000;
    idle(4);
    rd(9'h000, 32'h1234_0F0F, "R3 mixed pins");
    // R4 per-bank flags
    rd(9'h120, 32'h1, "R4 bank1 flag");
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h0, "R5 clear");
    ext2 = 32'h1;
    idle(4);
    rd(9'h120, 32'h2, "R4 bank2 flag");
    chk("R6 no irq without enables", {31'b0, m_irq}, 32'h0);
    // R6 interrupt gating
    wr(9'h128, 32'h2);
    chk("R6 no irq without master", {31'b0, m_irq}, 32'h0);
    wr(9'h11C, 32'h8000_0000);
    chk("R6 irq raised", {31'b0, m_irq}, 32'h1);
    rd(9'h11C, 32'h8000_0000, "R6 master readback");
    wr(9'h128, 32'h1);
    chk("R6 masked bank", {31'b0, m_irq}, 32'h0);
    wr(9'h128, 32'h3);
    chk("R6 irq both enabled", {31'b0, m_irq}, 32'h1);
    wr(9'h120, 32'h2);
    chk("R5 clear drops irq", {31'b0, m_irq}, 32'h0);
    // R5 set beats clear
    ext1[31] = 1'b1;
    idle(4);
    rd(9'h120, 32'h1, "R4 flag again");
    ext1[31] = 1'b0;
    idle(2);
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h1, "R5 set wins over clear");
    chk("R6 irq pending", {31'b0, m_irq}, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, 32'h0, "R5 later clear");
    // R7 unused bits and offsets
    wr(9'h11C, 32'h7FFF_FFFF);
    rd(9'h11C, 32'h0, "R7 master low bits");
    wr(9'h010, 32'hFFFF_FFFF);
    rd(9'h010, 32'h0, "R7 unmapped read");
    rd(9'h124, 32'h0, "R7 unmapped gap");
    wr(9'h128, 32'hFFFF_FFFF);
    rd(9'h128, 32'h3, "R7 mask width");
    wr(9'h120, 32'hFFFF_FFFC);
    rd(9'h120, 32'h0, "R7 status upper bits");
    rd(9'h004, 32'hFFFF_0000, "R7 unmapped write no effect");
    idle(2);
    // R9 single-bank instance, 8-bit bank 1
    use_single = 1'b1;
    chk("R1 single out reset", {24'b0, s_out1}, 32'h3C);
    chk("R1 single oe reset", {24'b0, s_oe1}, 32'hF0);
    chk("R9 ch2_oe zero", s_oe2, 32'h0);
    chk("R9 ch2_out zero", s_out2, 32'h0);
    rd(9'h000, 32'h30, "R3 single pad read");
    rd(9'h120, 32'h1, "R4 single flag after reset");
    ext2 = 32'hFFFF_0000;
    idle(4);
    rd(9'h120, 32'h1, "R9 bank2 flag absent");
    rd(9'h008, 32'h0, "R9 data2 zero");
    rd(9'h00C, 32'h0, "R9 dir2 zero");
    wr(9'h00C, 32'h0);
    chk("R9 ch2_oe after write", s_oe2, 32'h0);
    wr(9'h128, 32'h3);
    rd(9'h128, 32'h1, "R9 mask bit1 absent");
    wr(9'h004, 32'hFFFF_FFFF);
    rd(9'h004, 32'h0000_00FF, "R7 width mask");
    chk("R7 oe width", {24'b0, s_oe1}, 32'h0);
    idle(3);
    chk("R8 all responses seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule